// File: doc/BRIEF.md
# Split-Load DAC Host Interface

This block connects an 8-bit host data bus to a 12-bit DAC code register. The host builds a 12-bit word in an internal staging register using two partial writes. One write carries the low eight bits. The other carries the top four bits, which arrive right justified on bus lines 3:0. Each partial write has its own active-low select. A shared active-low write strobe qualifies both selects. The two writes may come in either order.

A separate active-low load strobe moves the whole staged word into the DAC code register in one step. Only the DAC code register drives the output code. A status bit tells the host when both halves have been written since the last transfer.

All host signals are asynchronous to the system clock. Each one passes through a two-flop synchroniser, and edges are detected on the synchronised copies. A partial write is captured when its active-low overlap of select and write ends. The overlap ends on the rise of either strobe, whichever rises first. The data captured is the value that was on the bus during the last clock of the overlap.

Top module: `split_load_dac_if`

## Requirements
- R1: After reset, `dac_code_o` is 0 and `word_full_o` is 0. The staging register also clears to 0.
- R2: A write with `sel_lo_n_i` low and `wr_n_i` low loads `host_data_i[7:0]` into staging bits 7:0.
- R3: A write with `sel_hi_n_i` low and `wr_n_i` low loads `host_data_i[3:0]` into staging bits 11:8. Bus bits 7:4 are ignored for this write.
- R4: Capture happens when the select/write overlap ends, whichever of the two strobes rises first. The captured value is the bus value seen during the last synchronised clock of the overlap. Bus changes after the overlap has ended are not captured.
- R5: Writing the upper nibble before the low byte gives the same staged word as the reverse order.
- R6: `dac_code_o` changes only on a low-to-high transition of `load_n_i`. On that transition it takes the full 12-bit staging word. A transfer leaves the staging word unchanged, so a second load with no writes in between repeats the same code.
- R7: `word_full_o` rises once both halves have been written since the last transfer. A transfer clears it. A partial write that completes in the same clock as a transfer counts toward the next word.
- R8: A write with both selects low loads the low byte and the nibble together from the same bus value, and it sets both halves as written.
- R9: Timing is measured from the system clock edge at which a strobe's rising transition is first sampled. The resulting change of `dac_code_o` or `word_full_o` appears two clock edges after that edge, on the third edge counting it. A transfer in the same clock as a capture takes the staging word from before that capture.
- R10: `wr_n_i` pulsing with both selects high, or a select low while `wr_n_i` stays high, changes neither the staging word nor `word_full_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_data_i | input | 8 | Host data bus, right justified |
| sel_lo_n_i | input | 1 | Active-low select for the low byte |
| sel_hi_n_i | input | 1 | Active-low select for the upper nibble |
| wr_n_i | input | 1 | Active-low write strobe shared by both selects |
| load_n_i | input | 1 | Active-low load strobe; its rising edge transfers the word |
| dac_code_o | output | 12 | DAC code register |
| word_full_o | output | 1 | Both halves have been written since the last transfer |

## Verification
A corrupted staging word cannot be seen directly. It shows up only at the next transfer, which can be arbitrarily late. The bench therefore follows every write sequence with a load and compares the DAC code exactly. It also repeats a load with no writes in between, to show the staging word was kept. A wrong half-written flag is more visible: `word_full_o` goes wrong on the third clock edge after the strobe edge that ended the write. A wrong transfer edge shows at `dac_code_o` within the same window. The bench compares both outputs with its reference model on every clock.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;

    localparam int unsigned BUS_W_DEF       = 8;
    localparam int unsigned WORD_W_DEF      = 12;
    localparam int unsigned SYNC_STAGES_DEF = 2;

    // which partial writes end in a given clock
    typedef enum logic [1:0] {
        PART_NONE = 2'b00,
        PART_LO   = 2'b01,
        PART_HI   = 2'b10,
        PART_BOTH = 2'b11
    } part_e;

    typedef struct packed {
        logic wr_n;
        logic sel_lo_n;
        logic sel_hi_n;
        logic load_n;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{wr_n: 1'b1, sel_lo_n: 1'b1, sel_hi_n: 1'b1, load_n: 1'b1};

endpackage

// File: rtl/dac_if_sync.sv
module dac_if_sync #(
    parameter int unsigned W       = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_comb stage_d[g] = async_i;
        end else begin : g_next
            always_comb stage_d[g] = stage_q[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= stage_d[g];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/dac_if_capture.sv
module dac_if_capture
    import dac_if_pkg::*;
#(
    parameter int unsigned BUS_W  = BUS_W_DEF,
    parameter int unsigned WORD_W = WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              sel_lo_n,
    input  logic              sel_hi_n,
    input  logic [BUS_W-1:0]  data,
    output logic [WORD_W-1:0] word_o,
    output logic              lo_cap_o,
    output logic              hi_cap_o
);

    localparam int unsigned HI_W = WORD_W - BUS_W;

    typedef struct packed {
        logic              lo_act;
        logic              hi_act;
        logic [BUS_W-1:0]  hold;
        logic [WORD_W-1:0] word;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic       lo_now, hi_now;
    part_e      ended;

    always_comb begin
        lo_now = !wr_n && !sel_lo_n;
        hi_now = !wr_n && !sel_hi_n;
        ended  = part_e'({st_q.hi_act && !hi_now, st_q.lo_act && !lo_now});

        st_d        = st_q;
        st_d.lo_act = lo_now;
        st_d.hi_act = hi_now;
        st_d.hold   = data;

        if (ended == PART_LO || ended == PART_BOTH)
            st_d.word[BUS_W-1:0] = st_q.hold;
        if (ended == PART_HI || ended == PART_BOTH)
            st_d.word[WORD_W-1:BUS_W] = st_q.hold[HI_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o   = st_q.word;
    assign lo_cap_o = (ended == PART_LO) || (ended == PART_BOTH);
    assign hi_cap_o = (ended == PART_HI) || (ended == PART_BOTH);

    // R2: low byte of the staging word moves only when a low-byte write ends
    assert_lo_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_cap_o |=> $stable(word_o[BUS_W-1:0]));

    // R3: nibble of the staging word moves only when a nibble write ends
    assert_hi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_cap_o |=> $stable(word_o[WORD_W-1:BUS_W]));

endmodule

// File: rtl/split_load_dac_if.sv
module split_load_dac_if
    import dac_if_pkg::*;
#(
    parameter int unsigned BUS_W       = BUS_W_DEF,
    parameter int unsigned WORD_W      = WORD_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  host_data_i,
    input  logic              sel_lo_n_i,
    input  logic              sel_hi_n_i,
    input  logic              wr_n_i,
    input  logic              load_n_i,
    output logic [WORD_W-1:0] dac_code_o,
    output logic              word_full_o
);

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic              load_prev;
        logic [WORD_W-1:0] dac;
        logic              lo_done;
        logic              hi_done;
    } top_state_t;

    ctrl_t             ctrl_raw, ctrl_s;
    logic [CTRL_W-1:0] ctrl_s_vec;
    logic [BUS_W-1:0]  data_s;
    logic [WORD_W-1:0] staged;
    logic              lo_cap, hi_cap, xfer;
    top_state_t        st_d, st_q;

    assign ctrl_raw = '{wr_n: wr_n_i, sel_lo_n: sel_lo_n_i, sel_hi_n: sel_hi_n_i, load_n: load_n_i};

    dac_if_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) u_ctrl_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ctrl_raw),
        .sync_o  (ctrl_s_vec)
    );
    assign ctrl_s = ctrl_t'(ctrl_s_vec);

    dac_if_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (host_data_i),
        .sync_o  (data_s)
    );

    dac_if_capture #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_n     (ctrl_s.wr_n),
        .sel_lo_n (ctrl_s.sel_lo_n),
        .sel_hi_n (ctrl_s.sel_hi_n),
        .data     (data_s),
        .word_o   (staged),
        .lo_cap_o (lo_cap),
        .hi_cap_o (hi_cap)
    );

    always_comb begin
        xfer           = ctrl_s.load_n && !st_q.load_prev;
        st_d           = st_q;
        st_d.load_prev = ctrl_s.load_n;
        if (xfer) begin
            st_d.dac     = staged;
            st_d.lo_done = 1'b0;
            st_d.hi_done = 1'b0;
        end
        if (lo_cap) st_d.lo_done = 1'b1;
        if (hi_cap) st_d.hi_done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{load_prev: 1'b1, dac: '0, lo_done: 1'b0, hi_done: 1'b0};
        else        st_q <= st_d;
    end

    assign dac_code_o  = st_q.dac;
    assign word_full_o = st_q.lo_done && st_q.hi_done;

    // R6: output code holds unless a load edge was detected
    assert_dac_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(dac_code_o));

    // R7: a transfer with no capture in the same clock leaves the status low
    assert_full_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !lo_cap && !hi_cap) |=> !word_full_o);

    // R7: status can only rise in the clock after a partial write ends
    assert_full_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_full_o) |-> $past(lo_cap || hi_cap));

endmodule

// File: tb/sim_split_load_dac_if.sv
module sim_split_load_dac_if;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  data = 8'h00;
    logic        sel_lo_n = 1'b1, sel_hi_n = 1'b1, wr_n = 1'b1, load_n = 1'b1;
    logic [11:0] dac_code;
    logic        word_full;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    split_load_dac_if u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_data_i (data),
        .sel_lo_n_i  (sel_lo_n),
        .sel_hi_n_i  (sel_hi_n),
        .wr_n_i      (wr_n),
        .load_n_i    (load_n),
        .dac_code_o  (dac_code),
        .word_full_o (word_full)
    );

    // reference model: pin history, newest first; bits {data, load, hi, lo, wr}
    logic [11:0] hist[$];
    logic [11:0] m_word, m_dac;
    logic        m_lo, m_hi;

    function automatic logic act_lo(logic [11:0] s); return !s[0] && !s[1]; endfunction
    function automatic logic act_hi(logic [11:0] s); return !s[0] && !s[2]; endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_word = '0; m_dac = '0; m_lo = 1'b0; m_hi = 1'b0;
            hist = '{12'h00F, 12'h00F, 12'h00F, 12'h00F};
        end else begin
            logic [11:0] h2, h3, nw;
            logic lo_end, hi_end, ld;
            hist.push_front({data, load_n, sel_hi_n, sel_lo_n, wr_n});
            h2 = hist[2];
            h3 = hist[3];
            lo_end = act_lo(h3) && !act_lo(h2);
            hi_end = act_hi(h3) && !act_hi(h2);
            ld     = !h3[3] && h2[3];
            nw = m_word;
            if (lo_end) nw[7:0]  = h3[11:4];
            if (hi_end) nw[11:8] = h3[7:4];
            if (ld) begin m_dac = m_word; m_lo = 1'b0; m_hi = 1'b0; end
            if (lo_end) m_lo = 1'b1;
            if (hi_end) m_hi = 1'b1;
            m_word = nw;
            void'(hist.pop_back());
        end
    end

    task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // R9: per-clock comparison with the model covers synchroniser latency
    always @(negedge clk) begin
        if (rst_n && hist.size() == 4) begin
            chk("R9", dac_code, m_dac);
            chk("R9", {11'd0, word_full}, {11'd0, m_lo && m_hi});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(logic lo, logic hi, logic [7:0] v);
        @(negedge clk);
        data = v; sel_lo_n = !lo; sel_hi_n = !hi;
        @(negedge clk); wr_n = 1'b0;
        idle(3);
        wr_n = 1'b1;
        @(negedge clk); sel_lo_n = 1'b1; sel_hi_n = 1'b1; data = ~v;
        idle(5);
    endtask

    task automatic host_load();
        @(negedge clk); load_n = 1'b0;
        idle(3);
        load_n = 1'b1;
        idle(5);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        chk("R1", dac_code, 12'h000);
        chk("R1", {11'd0, word_full}, 12'h000);

        // low byte then nibble; bus bits 7:4 on the nibble write ignored
        host_write(1'b1, 1'b0, 8'hA5);
        chk("R7", {11'd0, word_full}, 12'h000);
        chk("R6", dac_code, 12'h000);
        host_write(1'b0, 1'b1, 8'hF3);
        chk("R7", {11'd0, word_full}, 12'h001);
        chk("R6", dac_code, 12'h000);
        host_load();
        chk("R2", dac_code, 12'h3A5);
        chk("R3", dac_code, 12'h3A5);
        chk("R7", {11'd0, word_full}, 12'h000);

        // reversed order
        host_write(1'b0, 1'b1, 8'h0C);
        host_write(1'b1, 1'b0, 8'h5A);
        host_load();
        chk("R5", dac_code, 12'hC5A);

        // R4: overlap ended by select while write still low; later bus values ignored
        @(negedge clk); data = 8'h11; sel_lo_n = 1'b0;
        @(negedge clk); wr_n = 1'b0;
        idle(3);
        data = 8'h22;
        idle(3);
        sel_lo_n = 1'b1;
        idle(3);
        data = 8'h33;
        idle(3);
        wr_n = 1'b1;
        idle(5);
        host_write(1'b0, 1'b1, 8'h00);
        host_load();
        chk("R4", dac_code, 12'h022);

        // R10: write without select, select without write
        @(negedge clk); data = 8'hFF; wr_n = 1'b0;
        idle(3); wr_n = 1'b1;
        idle(2); sel_lo_n = 1'b0; sel_hi_n = 1'b0;
        idle(3); sel_lo_n = 1'b1; sel_hi_n = 1'b1;
        idle(5);
        chk("R10", {11'd0, word_full}, 12'h000);
        host_load();
        chk("R10", dac_code, 12'h022);

        // R8: both selects in one write
        host_write(1'b1, 1'b1, 8'hB7);
        chk("R8", {11'd0, word_full}, 12'h001);
        host_load();
        chk("R8", dac_code, 12'h7B7);

        // R6: repeat load with no writes keeps the staged word
        host_load();
        chk("R6", dac_code, 12'h7B7);
        chk("R7", {11'd0, word_full}, 12'h000);

        // R9: exact transfer latency
        host_write(1'b1, 1'b0, 8'h01);
        @(negedge clk); load_n = 1'b0;
        idle(3);
        load_n = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R9", dac_code, 12'h7B7);
        @(posedge clk); @(negedge clk);
        chk("R9", dac_code, 12'h701);
        idle(5);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule